// File: doc/BRIEF.md
# PWM Shared Control and Interrupt Register Block

This block is the common register front end of a small multi-channel pulse-width modulator. A host reaches it over a simple 32-bit memory-mapped bus with no wait states: read data is returned in the same cycle as the request, and writes take effect at the clock edge that ends the request. The block keeps one run bit per channel and drives it straight to that channel. It also keeps one interrupt mask bit and one interrupt pending bit per channel, and it combines them into a single interrupt line.

Run bits and mask bits are never written directly. Each set has one address that sets bits where the written word holds a 1, and another address that clears bits where the written word holds a 1. Each channel reports the end of every output period with a one-cycle pulse, which marks that channel pending. Reading the pending register returns all pending bits and clears them in the same access. A period-end pulse that arrives during that read stays pending.

Accesses that fall inside a channel's register window are passed through to that channel. The block provides a one-hot select, the word offset within the window, the write flag and the write data, and it returns that channel's read data. The clock-divider mode word and the channel counters live elsewhere.

Top module: `pwm_shared_regs`

## Requirements
- R1: After reset every run bit, mask bit and pending bit is 0, `chan_run` is 0 and `irq` is low.
- R2: A write to byte offset 0x04 sets run bit n for every bit n that is 1 in the written word. Bits written as 0 leave their run bits unchanged, and `chan_run` shows the new value from the cycle after the write.
- R3: A write to byte offset 0x08 clears run bit n for every bit n that is 1 in the written word. Bits written as 0 leave their run bits unchanged.
- R4: A read of byte offset 0x0C returns the run bits in bits [NCH-1:0] and zero in every higher bit.
- R5: Writes to byte offset 0x10 set mask bits and writes to 0x14 clear mask bits, each with the same write-one rule as R2 and R3. A read of 0x18 returns the mask, zero-extended.
- R6: A 1 on `period_end[n]` for one cycle sets pending bit n at the next edge, whatever the mask holds. The bit then stays set until the pending register is read.
- R7: A read of byte offset 0x1C returns the pending bits as they were before the access and clears them. When a period-end pulse arrives in the same cycle as that read, its bit is set after the read.
- R8: `irq` is high in exactly those cycles where the registered pending bits ANDed with the registered mask bits are non-zero.
- R9: Channel n's window spans byte addresses 0x200 + n*0x20 to 0x21F + n*0x20. Room is reserved for 32 windows. For an access in the window of an implemented channel (n < NCH), `chan_sel` is one-hot at bit n, `chan_woff` holds the word offset within the window, and `bus_rdata` returns `chan_rdata[n*32 +: 32]`. Outside those windows `chan_sel` is 0.
- R10: Reads of byte offsets 0x00, 0x04, 0x08, 0x10 and 0x14, of windows of unimplemented channels, and of unmapped addresses return 0. Writes to 0x00, 0x0C, 0x18 and 0x1C change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word address (byte address bits 11:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| period_end | input | NCH | One-cycle end-of-period pulse per channel |
| chan_run | output | NCH | Run bit per channel |
| irq | output | 1 | Combined interrupt |
| chan_sel | output | NCH | One-hot channel window select |
| chan_write | output | 1 | Write flag passed to the channel |
| chan_woff | output | 3 | Word offset inside the channel window |
| chan_wdata | output | 32 | Write data passed to the channel |
| chan_rdata | input | NCH*32 | Read data from every channel, channel 0 in the low word |

## Verification
The assertions check on every cycle that set and clear strobes take effect on the following edge and that bits with no strobe hold their value. They also check that pending bits latch every pulse and do not change without cause, that a pending read with no concurrent pulse empties the register, and that channel selects are never more than one-hot. What only the bench's scenarios can show are the address-level facts: that each offset maps to the right register, that read-only and write-only offsets ignore the wrong kind of access, that windows of unimplemented channels read zero, and that a pulse during a pending read survives while the read returns the old value.

// File: rtl/pwmr_pkg.sv
package pwmr_pkg;

  // Global register selected by a word address below the channel windows.
  typedef enum logic [3:0] {
    GR_NONE,
    GR_RUN_SET,
    GR_RUN_CLR,
    GR_RUN_STAT,
    GR_MSK_SET,
    GR_MSK_CLR,
    GR_MSK_STAT,
    GR_PEND
  } greg_e;

  // Word index (byte offset / 4) to global register.
  function automatic greg_e greg_of(input logic [2:0] word);
    case (word)
      3'd1:    return GR_RUN_SET;
      3'd2:    return GR_RUN_CLR;
      3'd3:    return GR_RUN_STAT;
      3'd4:    return GR_MSK_SET;
      3'd5:    return GR_MSK_CLR;
      3'd6:    return GR_MSK_STAT;
      3'd7:    return GR_PEND;
      default: return GR_NONE;
    endcase
  endfunction

  // Next state of a write-one set / write-one clear register.
  function automatic logic [31:0] w1_update(input logic [31:0] cur,
                                            input logic [31:0] set_bits,
                                            input logic [31:0] clr_bits);
    return (cur | set_bits) & ~clr_bits;
  endfunction

  // Next state of a clear-on-read pending register; new events win.
  function automatic logic [31:0] pend_update(input logic [31:0] cur,
                                              input logic        rd_clr,
                                              input logic [31:0] evt);
    return (rd_clr ? 32'd0 : cur) | evt;
  endfunction

endpackage

// File: rtl/pwmr_decode.sv
module pwmr_decode
  import pwmr_pkg::*;
#(
  parameter int WA_W     = 10,
  parameter int NCH      = 4,
  parameter int MAX_CH   = 32,
  parameter int BASE_W   = 'h80,
  parameter int STRIDE_W = 8,
  parameter int OFF_W    = $clog2(STRIDE_W),
  parameter int IDX_W    = $clog2(MAX_CH)
) (
  input  logic [WA_W-1:0]  waddr,
  output greg_e            greg,
  output logic             ch_hit,
  output logic [IDX_W-1:0] ch_idx,
  output logic [OFF_W-1:0] ch_off
);

  localparam logic [WA_W-1:0] WIN_LO = WA_W'(BASE_W);

  logic [WA_W-1:0] rel;
  logic            in_win;

  always_comb begin
    greg = (waddr[WA_W-1:3] == '0) ? greg_of(waddr[2:0]) : GR_NONE;
  end

  always_comb begin
    rel    = waddr - WIN_LO;
    in_win = (waddr >= WIN_LO) && (rel[WA_W-1:OFF_W+IDX_W] == '0);
    ch_idx = rel[OFF_W +: IDX_W];
    ch_off = rel[OFF_W-1:0];
    ch_hit = in_win && (32'(ch_idx) < NCH);
  end

endmodule

// File: rtl/pwmr_w1_bits.sv
module pwmr_w1_bits
  import pwmr_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [N-1:0] bits,
  output logic [N-1:0] q
);

  logic [N-1:0] set_bits;
  logic [N-1:0] clr_bits;
  logic [N-1:0] q_nxt;

  assign set_bits = set_stb ? bits : '0;
  assign clr_bits = clr_stb ? bits : '0;

  always_comb begin
    q_nxt = N'(w1_update(32'(q), 32'(set_bits), 32'(clr_bits)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((q & $past(bits)) == $past(bits))); // R2 R5
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((q & $past(bits)) == '0)); // R3 R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(q)); // R10
  AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb || clr_stb) |=> ((q & ~$past(bits)) == ($past(q) & ~$past(bits)))); // R2

endmodule

// File: rtl/pwmr_pending.sv
module pwmr_pending
  import pwmr_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         rd_clr,
  output logic [N-1:0] pend
);

  logic [N-1:0] pend_nxt;

  always_comb begin
    pend_nxt = N'(pend_update(32'(pend), rd_clr, 32'(evt)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end

  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend & $past(evt)) == $past(evt))); // R6
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt == '0) |=> (pend == '0)); // R7
  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && evt == '0) |=> $stable(pend)); // R6

endmodule

// File: rtl/pwm_shared_regs.sv
module pwm_shared_regs
  import pwmr_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int MAX_CH    = 32,
  parameter int BYTE_AW   = 12,
  parameter int CH_BASE   = 'h200,
  parameter int CH_STRIDE = 'h20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [BYTE_AW-3:0]   bus_waddr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NCH-1:0]       period_end,
  output logic [NCH-1:0]       chan_run,
  output logic                 irq,
  output logic [NCH-1:0]       chan_sel,
  output logic                 chan_write,
  output logic [$clog2(CH_STRIDE/4)-1:0] chan_woff,
  output logic [31:0]          chan_wdata,
  input  logic [NCH*32-1:0]    chan_rdata
);

  localparam int WA_W     = BYTE_AW - 2;
  localparam int BASE_W   = CH_BASE / 4;
  localparam int STRIDE_W = CH_STRIDE / 4;
  localparam int OFF_W    = $clog2(STRIDE_W);
  localparam int IDX_W    = $clog2(MAX_CH);

  greg_e            greg;
  logic             ch_hit;
  logic [IDX_W-1:0] ch_idx;
  logic [OFF_W-1:0] ch_off;

  logic             wr_acc;
  logic             rd_acc;
  logic             run_set_stb;
  logic             run_clr_stb;
  logic             msk_set_stb;
  logic             msk_clr_stb;
  logic             pend_read;
  logic [NCH-1:0]   irq_mask;
  logic [NCH-1:0]   irq_pend;
  logic [31:0]      chan_rd_mux;

  pwmr_decode #(
    .WA_W(WA_W), .NCH(NCH), .MAX_CH(MAX_CH),
    .BASE_W(BASE_W), .STRIDE_W(STRIDE_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) u_decode (
    .waddr (bus_waddr),
    .greg  (greg),
    .ch_hit(ch_hit),
    .ch_idx(ch_idx),
    .ch_off(ch_off)
  );

  assign wr_acc      = bus_valid &&  bus_write;
  assign rd_acc      = bus_valid && !bus_write;
  assign run_set_stb = wr_acc && (greg == GR_RUN_SET);
  assign run_clr_stb = wr_acc && (greg == GR_RUN_CLR);
  assign msk_set_stb = wr_acc && (greg == GR_MSK_SET);
  assign msk_clr_stb = wr_acc && (greg == GR_MSK_CLR);
  assign pend_read   = rd_acc && (greg == GR_PEND);

  pwmr_w1_bits #(.N(NCH)) u_run (
    .clk(clk), .rst_n(rst_n),
    .set_stb(run_set_stb), .clr_stb(run_clr_stb),
    .bits(bus_wdata[NCH-1:0]), .q(chan_run)
  );

  pwmr_w1_bits #(.N(NCH)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_stb(msk_set_stb), .clr_stb(msk_clr_stb),
    .bits(bus_wdata[NCH-1:0]), .q(irq_mask)
  );

  pwmr_pending #(.N(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .evt(period_end), .rd_clr(pend_read), .pend(irq_pend)
  );

  assign irq = |(irq_pend & irq_mask);

  // Channel window pass-through.
  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign chan_sel[i] = bus_valid && ch_hit && (ch_idx == IDX_W'(i));
  end

  assign chan_write = bus_write;
  assign chan_woff  = ch_off;
  assign chan_wdata = bus_wdata;

  always_comb begin
    chan_rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (chan_sel[i]) chan_rd_mux = chan_rd_mux | chan_rdata[i*32 +: 32];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      case (greg)
        GR_RUN_STAT: bus_rdata = 32'(chan_run);
        GR_MSK_STAT: bus_rdata = 32'(irq_mask);
        GR_PEND:     bus_rdata = 32'(irq_pend);
        default:     bus_rdata = chan_rd_mux;
      endcase
    end
  end

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_sel)); // R9
  AST_STAT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && greg == GR_RUN_STAT) |-> ((bus_rdata >> NCH) == '0)); // R4
  AST_IRQ_QUIET_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq); // R8
  AST_SEL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (chan_sel == '0)); // R9

endmodule

// File: tb/test_pwm_shared_regs.sv
module test_pwm_shared_regs;

  localparam int NCH = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [9:0]        bus_waddr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NCH-1:0]    period_end = '0;
  logic [NCH-1:0]    chan_run;
  logic              irq;
  logic [NCH-1:0]    chan_sel;
  logic              chan_write;
  logic [2:0]        chan_woff;
  logic [31:0]       chan_wdata;
  logic [NCH*32-1:0] chan_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [NCH-1:0] m_run, m_mask, m_pend;

  always #2 clk = ~clk;

  pwm_shared_regs i_pwm_shared_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .period_end(period_end), .chan_run(chan_run), .irq(irq),
    .chan_sel(chan_sel), .chan_write(chan_write), .chan_woff(chan_woff),
    .chan_wdata(chan_wdata), .chan_rdata(chan_rdata)
  );

  function automatic logic [31:0] chan_val(input int n);
    return 32'h5A00_0000 + 32'(n) * 32'h0011_0203 + 32'h77;
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_cr
    assign chan_rdata[g*32 +: 32] = chan_val(g);
  end

  // Window slot of a word address, -1 when not inside any of the 32 slots.
  function automatic int slot_of(input logic [9:0] wa);
    if (wa >= 10'h080 && wa < 10'h180) return (int'(wa) - 'h80) / 8;
    return -1;
  endfunction

  function automatic logic [31:0] exp_read(input logic [9:0] wa);
    int s = slot_of(wa);
    if (wa == 10'd3) return 32'(m_run);
    if (wa == 10'd6) return 32'(m_mask);
    if (wa == 10'd7) return 32'(m_pend);
    if (s >= 0 && s < NCH) return chan_val(s);
    return 32'd0;
  endfunction

  function automatic logic [NCH-1:0] exp_sel(input logic [9:0] wa);
    int s = slot_of(wa);
    if (s >= 0 && s < NCH) return NCH'(1) << s;
    return '0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle; v=0 gives an idle cycle. Checks reads, selects, and state.
  task automatic cyc(input bit v, input bit w, input logic [9:0] wa,
                     input logic [31:0] wd, input logic [NCH-1:0] ev);
    logic [31:0] er;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_waddr = wa; bus_wdata = wd; period_end = ev;
    #1;
    if (v) begin
      chk("R9 sel", 32'(chan_sel), 32'(exp_sel(wa)));
      if (exp_sel(wa) != '0) chk("R9 woff", 32'(chan_woff), 32'(wa[2:0]));
      if (!w) begin
        er = exp_read(wa);
        chk((wa == 10'd7) ? "R7 pend read" : (wa < 10'd8) ? "R10/R4/R5 glob read" : "R9/R10 win read",
            bus_rdata, er);
      end
    end else begin
      chk("R9 idle sel", 32'(chan_sel), 32'd0);
    end
    @(posedge clk);
    if (v && w && wa == 10'd1) m_run  = m_run  | wd[NCH-1:0];
    if (v && w && wa == 10'd2) m_run  = m_run  & ~wd[NCH-1:0];
    if (v && w && wa == 10'd4) m_mask = m_mask | wd[NCH-1:0];
    if (v && w && wa == 10'd5) m_mask = m_mask & ~wd[NCH-1:0];
    m_pend = ((v && !w && wa == 10'd7) ? '0 : m_pend) | ev;
    #1;
    chk("R2/R3 run", 32'(chan_run), 32'(m_run));
    chk("R8 irq", 32'(irq), 32'(|(m_pend & m_mask)));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_run = '0; m_mask = '0; m_pend = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 run", 32'(chan_run), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    cyc(1, 0, 10'd6, 0, 0);       // R1 mask reads zero
    cyc(1, 0, 10'd7, 0, 0);       // R1 pending reads zero

    // R2: set with ones, zeros leave bits
    cyc(1, 1, 10'd1, 32'h5, 0);
    cyc(1, 1, 10'd1, 32'h0, 0);
    cyc(1, 0, 10'd3, 0, 0);       // R4
    // R3: clear one bit
    cyc(1, 1, 10'd2, 32'h1, 0);
    cyc(1, 1, 10'd1, 32'hFFFF_FFFF, 0);
    cyc(1, 0, 10'd3, 0, 0);       // R4 high bits zero
    // R10: writes to read-only offsets ignored
    cyc(1, 1, 10'd3, 32'h0, 0);
    cyc(1, 1, 10'd0, 32'hFFFF_FFFF, 0);
    cyc(1, 0, 10'd1, 0, 0);       // R10 write-only reads zero
    cyc(1, 0, 10'd0, 0, 0);

    // R5 mask set/clear
    cyc(1, 1, 10'd4, 32'hA, 0);
    cyc(1, 1, 10'd5, 32'h2, 0);
    cyc(1, 0, 10'd6, 0, 0);

    // R6 event with masked and unmasked bits, R8 irq
    cyc(0, 0, 0, 0, 4'b0001);     // pending unmasked: irq low
    cyc(0, 0, 0, 0, 4'b1000);     // masked: irq high
    cyc(1, 1, 10'd7, 32'hF, 0);   // R10 write to pending ignored
    // R7 read clears, concurrent event survives
    cyc(1, 0, 10'd7, 0, 4'b0100);
    cyc(1, 0, 10'd7, 0, 0);
    cyc(1, 0, 10'd7, 0, 0);

    // R9 windows: each implemented channel, offset, and unimplemented one
    for (int c = 0; c < 6; c++) cyc(1, 0, 10'(10'h080 + c * 8 + c % 8), 0, 0);
    cyc(1, 1, 10'h089, 32'h1234, 0);
    cyc(1, 0, 10'h17F, 0, 0);
    cyc(1, 0, 10'h180, 0, 0);
    cyc(1, 0, 10'h07F, 0, 0);

    // Constrained random mix
    for (int k = 0; k < 1500; k++) begin
      logic [9:0] wa;
      int r = $urandom % 4;
      case (r)
        0: wa = 10'($urandom % 8);
        1: wa = 10'(10'h080 + $urandom % 'h100);
        2: wa = 10'($urandom);
        default: wa = ($urandom % 2) ? 10'd3 : 10'd7;
      endcase
      cyc(($urandom % 5) != 0, $urandom % 2, wa, $urandom,
          (($urandom % 4) == 0) ? NCH'($urandom) : '0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule